// File: doc/BRIEF.md
# Error, NMI and Alert Status Controller

This block sits beside a processor core. It gathers fault events from the core and from the core's bus interface into one status word. Each fault sets its own bit, and the bit stays set until software writes a 1 to that position.

The block also combines two non-maskable interrupt sources into a single NMI line to the core. The sources are an alert-escalation request and a watchdog bark. Each source has an enable bit and a raised bit. A source is recorded only while it is enabled, and it drives the line only while it is both enabled and raised.

Software can also raise two alerts by writing a control register. The recoverable alert fires once and then disarms itself. The fatal alert latches and stays asserted until the next reset. All state is reached through a small word-addressed register port with a single-cycle write strobe and a combinational read.

Top module: `fault_nmi_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `nmi_o`, `alert_recov_o` and `alert_fatal_o` are all low.
- R2: A pulse on `err_evt_i[0]`, `[1]`, `[2]` or `[3]` sets error-status bit 0, 8, 9 or 10 respectively. The bit is visible at address 0 in the cycle after the edge that samples the pulse. No other status bit is ever set.
- R3: A write to address 0 clears the status bits where the write data holds 1 and leaves every other bit unchanged.
- R4: If an error event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Address 1 is the NMI enable register. Bits [1:0] are readable and writable, with bit 0 for the alert source and bit 1 for the watchdog source.
- R6: An NMI event pulse (`nmi_evt_i[0]` alert, `nmi_evt_i[1]` watchdog) sets the source's raised bit at address 2 only if that source's enable bit was 1 in the same cycle. Otherwise it is dropped.
- R7: A write to address 2 clears the raised bits where the data holds 1. A new event in the same cycle wins over the clear.
- R8: `nmi_o` is high exactly when some source is both enabled and raised. Clearing an enable bit drops `nmi_o` but keeps that source's raised bit.
- R9: Writing 1 to bit 0 of address 3 drives `alert_recov_o` high for exactly one cycle, and bit 0 then reads back 0 again.
- R10: Writing 1 to bit 1 of address 3 drives `alert_fatal_o` high from the next cycle until reset. Later writes of 0 have no effect on it.
- R11: Unimplemented bits and addresses 4 to 7 read as 0, and writes to addresses 4 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Word address for both read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| err_evt_i | input | 4 | Fault event pulses: register integrity, response integrity, fatal internal, recoverable internal |
| nmi_evt_i | input | 2 | NMI event pulses: bit 0 alert escalation, bit 1 watchdog bark |
| nmi_o | output | 1 | Non-maskable interrupt request to the core |
| alert_recov_o | output | 1 | Recoverable software alert request |
| alert_fatal_o | output | 1 | Fatal software alert request |

## Verification
The fault inputs are driven one at a time and then all together. Single pulses show whether each source lands on its own bit position, and the combined pulse shows whether sources interfere with one another. Clearing writes use partial masks, masks that include unimplemented bits, and masks that coincide with a new event on the same bit; together these separate a correct write-1-to-clear bank with set priority from a plain overwrite or a clear-wins design. The NMI sources are pulsed while disabled, while enabled, and across a disable, which distinguishes gating at capture time from gating at the output. The two software alerts are triggered, rewritten with zero and left idle, so that a self-clearing pulse and a permanent latch show different traces.

// File: rtl/fault_nmi_pkg.sv
package fault_nmi_pkg;

   // Number of fault sources feeding the status word.
   localparam int unsigned ERR_SRC_N = 4;

   // Register word addresses; decoding depends on these.
   localparam int unsigned ADR_ERR    = 0;
   localparam int unsigned ADR_NMI_EN = 1;
   localparam int unsigned ADR_NMI_RS = 2;
   localparam int unsigned ADR_SWALRT = 3;

   // Bit positions inside the software alert register.
   localparam int unsigned SWA_RECOV_BIT = 0;
   localparam int unsigned SWA_FATAL_BIT = 1;

   // Highest status bit used; the data path must be wider than this.
   localparam int unsigned ERR_TOP_BIT = 10;

   // Status bit fed by fault source idx.
   function automatic int unsigned err_bit_of(input int unsigned idx);
      case (idx)
         0:       return 0;
         1:       return 8;
         2:       return 9;
         default: return 10;
      endcase
   endfunction

endpackage

// File: rtl/fnc_sticky_bank.sv
module fnc_sticky_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] q_r;

   // Sticky bits: the clear mask acts first and a set in the same cycle overrides it.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         q_r <= '0;
      end else begin
         q_r <= (q_r & ~clr_i) | set_i;
      end
   end

   assign q_o = q_r;

endmodule

// File: rtl/fnc_nmi_gate.sv
module fnc_nmi_gate #(
   parameter int unsigned N       = 2,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         en_we_i,
   input  logic [N-1:0] en_wdata_i,
   input  logic [N-1:0] clr_i,
   input  logic [N-1:0] evt_i,
   output logic [N-1:0] en_o,
   output logic [N-1:0] raised_o,
   output logic         nmi_o
);

   logic [N-1:0] en_q;
   logic [N-1:0] capture;
   logic         nmi_comb;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q <= '0;
      end else if (en_we_i) begin
         en_q <= en_wdata_i;
      end
   end

   // An event is recorded only for a source that is enabled in that cycle.
   assign capture = evt_i & en_q;

   fnc_sticky_bank #(
      .W (N)
   ) u_raised (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (capture),
      .clr_i  (clr_i),
      .q_o    (raised_o)
   );

   assign nmi_comb = |(en_q & raised_o);

   generate
      if (OUT_REG) begin : g_nmi_flop
         logic nmi_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               nmi_q <= 1'b0;
            end else begin
               nmi_q <= nmi_comb;
            end
         end
         assign nmi_o = nmi_q;
      end else begin : g_nmi_direct
         assign nmi_o = nmi_comb;
      end
   endgenerate

   assign en_o = en_q;

endmodule

// File: rtl/fnc_sw_alert.sv
module fnc_sw_alert (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic we_i,
   input  logic recov_req_i,
   input  logic fatal_req_i,
   output logic recov_o,
   output logic fatal_o
);

   logic recov_q;
   logic fatal_q;

   // Recoverable: armed for the single cycle after the write, then disarmed.
   // Fatal: latches and only reset releases it.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         recov_q <= 1'b0;
         fatal_q <= 1'b0;
      end else begin
         recov_q <= we_i & recov_req_i;
         fatal_q <= fatal_q | (we_i & fatal_req_i);
      end
   end

   assign recov_o = recov_q;
   assign fatal_o = fatal_q;

endmodule

// File: rtl/fault_nmi_ctrl.sv
module fault_nmi_ctrl #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned NMI_SRC     = 2,
   parameter bit          NMI_OUT_REG = 1'b0
) (
   input  logic                                   clk_i,
   input  logic                                   rst_ni,
   input  logic                                   reg_wr_i,
   input  logic [ADDR_W-1:0]                      reg_addr_i,
   input  logic [DATA_W-1:0]                      reg_wdata_i,
   output logic [DATA_W-1:0]                      reg_rdata_o,
   input  logic [fault_nmi_pkg::ERR_SRC_N-1:0]    err_evt_i,
   input  logic [NMI_SRC-1:0]                     nmi_evt_i,
   output logic                                   nmi_o,
   output logic                                   alert_recov_o,
   output logic                                   alert_fatal_o
);

   import fault_nmi_pkg::*;

   localparam int unsigned SWA_W = 2;

   generate
      if (DATA_W <= ERR_TOP_BIT) begin : g_chk_data_w
         $error("DATA_W too narrow for the status word");
      end
      if (ADDR_W < 2) begin : g_chk_addr_w
         $error("ADDR_W must decode four registers");
      end
      if (NMI_SRC < 1 || NMI_SRC > DATA_W) begin : g_chk_nmi
         $error("NMI_SRC out of range");
      end
   endgenerate

   // Mask of implemented status bits, derived from the source mapping.
   function automatic logic [DATA_W-1:0] err_impl_mask();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int unsigned i = 0; i < ERR_SRC_N; i++) begin
         m[err_bit_of(i)] = 1'b1;
      end
      return m;
   endfunction

   localparam logic [DATA_W-1:0] ERR_MASK = err_impl_mask();

   logic              sel_err, sel_en, sel_rs, sel_swa;
   logic [DATA_W-1:0] err_set;
   logic [DATA_W-1:0] err_clr;
   logic [DATA_W-1:0] err_q;
   logic [NMI_SRC-1:0] nmi_clr;
   logic [NMI_SRC-1:0] nmi_en_q;
   logic [NMI_SRC-1:0] nmi_raised_q;
   logic              swa_recov, swa_fatal;

   assign sel_err = (reg_addr_i == ADDR_W'(ADR_ERR));
   assign sel_en  = (reg_addr_i == ADDR_W'(ADR_NMI_EN));
   assign sel_rs  = (reg_addr_i == ADDR_W'(ADR_NMI_RS));
   assign sel_swa = (reg_addr_i == ADDR_W'(ADR_SWALRT));

   // Spread the fault pulses onto their status positions.
   always_comb begin
      err_set = '0;
      for (int unsigned i = 0; i < ERR_SRC_N; i++) begin
         err_set[err_bit_of(i)] = err_evt_i[i];
      end
   end

   assign err_clr = (reg_wr_i && sel_err) ? (reg_wdata_i & ERR_MASK) : '0;
   assign nmi_clr = (reg_wr_i && sel_rs) ? reg_wdata_i[NMI_SRC-1:0] : '0;

   fnc_sticky_bank #(
      .W (DATA_W)
   ) u_err_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (err_set),
      .clr_i  (err_clr),
      .q_o    (err_q)
   );

   fnc_nmi_gate #(
      .N       (NMI_SRC),
      .OUT_REG (NMI_OUT_REG)
   ) u_nmi (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_we_i    (reg_wr_i && sel_en),
      .en_wdata_i (reg_wdata_i[NMI_SRC-1:0]),
      .clr_i      (nmi_clr),
      .evt_i      (nmi_evt_i),
      .en_o       (nmi_en_q),
      .raised_o   (nmi_raised_q),
      .nmi_o      (nmi_o)
   );

   fnc_sw_alert u_swa (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .we_i        (reg_wr_i && sel_swa),
      .recov_req_i (reg_wdata_i[SWA_RECOV_BIT]),
      .fatal_req_i (reg_wdata_i[SWA_FATAL_BIT]),
      .recov_o     (swa_recov),
      .fatal_o     (swa_fatal)
   );

   assign alert_recov_o = swa_recov;
   assign alert_fatal_o = swa_fatal;

   always_comb begin
      reg_rdata_o = '0;
      if (sel_err) begin
         reg_rdata_o = err_q;
      end else if (sel_en) begin
         reg_rdata_o[NMI_SRC-1:0] = nmi_en_q;
      end else if (sel_rs) begin
         reg_rdata_o[NMI_SRC-1:0] = nmi_raised_q;
      end else if (sel_swa) begin
         reg_rdata_o[SWA_RECOV_BIT] = swa_recov;
         reg_rdata_o[SWA_FATAL_BIT] = swa_fatal;
      end
   end

   logic [SWA_W-1:0] unused_swa;
   assign unused_swa = '0;

endmodule

// File: rtl/fault_nmi_chk.sv
module fault_nmi_chk #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned NMI_SRC = 2
) (
   input logic                                clk_i,
   input logic                                rst_ni,
   input logic                                reg_wr_i,
   input logic [ADDR_W-1:0]                   reg_addr_i,
   input logic [DATA_W-1:0]                   reg_wdata_i,
   input logic [DATA_W-1:0]                   reg_rdata_o,
   input logic [fault_nmi_pkg::ERR_SRC_N-1:0] err_evt_i,
   input logic                                nmi_o,
   input logic                                alert_recov_o,
   input logic                                alert_fatal_o,
   input logic [DATA_W-1:0]                   err_q,
   input logic [NMI_SRC-1:0]                  nmi_en_q,
   input logic [NMI_SRC-1:0]                  nmi_raised_q
);

   import fault_nmi_pkg::*;

   logic [DATA_W-1:0] evt_pos;
   logic              rearm;

   always_comb begin
      evt_pos = '0;
      for (int unsigned i = 0; i < ERR_SRC_N; i++) begin
         evt_pos[err_bit_of(i)] = err_evt_i[i];
      end
   end

   assign rearm = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_SWALRT)) &&
                  reg_wdata_i[SWA_RECOV_BIT];

   // R2 (and R4): an event leaves its status bit set on the next cycle, whatever the write.
   assert_evt_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|err_evt_i) |=> ((err_q & $past(evt_pos)) == $past(evt_pos)));

   // R6: a raised bit never appears for a source that was disabled.
   assert_raise_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nmi_raised_q & ~$past(nmi_raised_q) & ~$past(nmi_en_q)) == '0);

   // R8: with every source disabled the NMI line stays low.
   assert_nmi_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nmi_en_q == '0) |-> !nmi_o);

   // R9: the recoverable alert lasts one cycle unless rearmed.
   assert_recov_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alert_recov_o && !rearm) |=> !alert_recov_o);

   // R10: the fatal alert never drops once raised.
   assert_fatal_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alert_fatal_o |=> alert_fatal_o);

   // R11: unimplemented addresses read as zero.
   assert_hole_reads_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_addr_i > ADDR_W'(ADR_SWALRT)) |-> (reg_rdata_o == '0));

endmodule

bind fault_nmi_ctrl fault_nmi_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .NMI_SRC (NMI_SRC)
) u_fault_nmi_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .reg_wr_i      (reg_wr_i),
   .reg_addr_i    (reg_addr_i),
   .reg_wdata_i   (reg_wdata_i),
   .reg_rdata_o   (reg_rdata_o),
   .err_evt_i     (err_evt_i),
   .nmi_o         (nmi_o),
   .alert_recov_o (alert_recov_o),
   .alert_fatal_o (alert_fatal_o),
   .err_q         (err_q),
   .nmi_en_q      (nmi_en_q),
   .nmi_raised_q  (nmi_raised_q)
);

// File: tb/fault_nmi_ctrl_bench.sv
module fault_nmi_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 3;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [3:0]    err_evt = '0;
   logic [1:0]    nmi_evt = '0;
   logic          nmi, a_recov, a_fatal;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    armed = 1'b0;
   bit    done = 1'b0;
   string tag = "R1";

   // Reference state
   logic [31:0] m_err;
   logic [1:0]  m_en, m_rs;
   logic        m_recov, m_fatal;

   always #(CLK_PERIOD/2) clk = ~clk;

   fault_nmi_ctrl u_fault_nmi_ctrl (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .reg_wr_i      (wr),
      .reg_addr_i    (addr),
      .reg_wdata_i   (wdata),
      .reg_rdata_o   (rdata),
      .err_evt_i     (err_evt),
      .nmi_evt_i     (nmi_evt),
      .nmi_o         (nmi),
      .alert_recov_o (a_recov),
      .alert_fatal_o (a_fatal)
   );

   function automatic logic [31:0] evt_to_bits(input logic [3:0] e);
      logic [31:0] b;
      b = '0;
      b[0]  = e[0];
      b[8]  = e[1];
      b[9]  = e[2];
      b[10] = e[3];
      return b;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_err = '0; m_en = '0; m_rs = '0; m_recov = 1'b0; m_fatal = 1'b0;
      end else begin
         logic [31:0] eclr;
         logic [1:0]  rclr;
         eclr = (wr && addr == 0) ? (wdata & 32'h0000_0701) : '0;
         rclr = (wr && addr == 2) ? wdata[1:0] : '0;
         m_err = (m_err & ~eclr) | evt_to_bits(err_evt);
         m_rs  = (m_rs & ~rclr) | (nmi_evt & m_en);
         if (wr && addr == 1) m_en = wdata[1:0];
         m_recov = wr && addr == 3 && wdata[0];
         m_fatal = m_fatal | (wr && addr == 3 && wdata[1]);
      end
   end

   function automatic logic [31:0] exp_rdata();
      case (addr)
         3'd0:    return m_err;
         3'd1:    return {30'd0, m_en};
         3'd2:    return {30'd0, m_rs};
         3'd3:    return {30'd0, m_fatal, m_recov};
         default: return '0;
      endcase
   endfunction

   task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (armed && !done) begin
         cmp("rdata", rdata, exp_rdata());
         cmp("nmi_o", {31'd0, nmi}, {31'd0, |(m_en & m_rs)});
         cmp("alert_recov_o", {31'd0, a_recov}, {31'd0, m_recov});
         cmp("alert_fatal_o", {31'd0, a_fatal}, {31'd0, m_fatal});
      end
   end

   task automatic cyc(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [3:0] e, input logic [1:0] n, input string t);
      @(negedge clk);
      #1;
      wr = w; addr = a; wdata = d; err_evt = e; nmi_evt = n; tag = t;
   endtask

   task automatic rd(input logic [AW-1:0] a, input string t);
      cyc(1'b0, a, '0, 4'd0, 2'd0, t);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(posedge clk);
      @(posedge clk);
      armed = 1'b1;
      // R1: reset values at every address
      for (int a = 0; a < 8; a++) rd(AW'(a), "R1");
      cyc(1'b0, 3'd0, '0, 4'd0, 2'd0, "R1");
      rst_n = 1'b1;
      for (int a = 0; a < 4; a++) rd(AW'(a), "R1");

      // R2: each fault source alone, then all together
      for (int i = 0; i < 4; i++) begin
         cyc(1'b0, 3'd0, '0, 4'(1 << i), 2'd0, "R2");
         rd(3'd0, "R2");
         cyc(1'b1, 3'd0, 32'hFFFF_FFFF, 4'd0, 2'd0, "R3");
      end
      cyc(1'b0, 3'd0, '0, 4'hF, 2'd0, "R2");
      rd(3'd0, "R2");

      // R3: partial mask, and a mask with unimplemented bits
      cyc(1'b1, 3'd0, 32'h0000_0101, 4'd0, 2'd0, "R3");
      rd(3'd0, "R3");
      cyc(1'b1, 3'd0, 32'hFFFF_F8FE, 4'd0, 2'd0, "R3");
      rd(3'd0, "R3");
      cyc(1'b1, 3'd0, 32'h0000_0600, 4'd0, 2'd0, "R3");
      rd(3'd0, "R3");

      // R4: event and clear of the same bit in one cycle
      cyc(1'b0, 3'd0, '0, 4'b0110, 2'd0, "R4");
      cyc(1'b1, 3'd0, 32'h0000_0300, 4'b0010, 2'd0, "R4");
      rd(3'd0, "R4");

      // R6: events while disabled are dropped
      cyc(1'b0, 3'd2, '0, 4'd0, 2'b11, "R6");
      rd(3'd2, "R6");

      // R5: enable register read/write
      cyc(1'b1, 3'd1, 32'hFFFF_FFFE, 4'd0, 2'd0, "R5");
      rd(3'd1, "R5");
      cyc(1'b1, 3'd1, 32'h0000_0001, 4'd0, 2'd0, "R5");
      rd(3'd1, "R5");

      // R6/R8: only the enabled alert source is captured
      cyc(1'b0, 3'd2, '0, 4'd0, 2'b11, "R6");
      rd(3'd2, "R8");
      // R8: disabling masks the line but keeps raised state
      cyc(1'b1, 3'd1, 32'h0000_0000, 4'd0, 2'd0, "R8");
      rd(3'd2, "R8");
      cyc(1'b1, 3'd1, 32'h0000_0003, 4'd0, 2'd0, "R8");
      cyc(1'b0, 3'd2, '0, 4'd0, 2'b10, "R8");
      rd(3'd2, "R8");

      // R7: clear raised bits, with and without a coinciding event
      cyc(1'b1, 3'd2, 32'h0000_0001, 4'd0, 2'd0, "R7");
      rd(3'd2, "R7");
      cyc(1'b1, 3'd2, 32'h0000_0003, 4'd0, 2'b10, "R7");
      rd(3'd2, "R7");
      cyc(1'b1, 3'd2, 32'h0000_0003, 4'd0, 2'd0, "R7");
      rd(3'd2, "R7");

      // R9: one-shot recoverable alert, then back to back
      cyc(1'b1, 3'd3, 32'h0000_0001, 4'd0, 2'd0, "R9");
      for (int k = 0; k < 3; k++) rd(3'd3, "R9");
      cyc(1'b1, 3'd3, 32'h0000_0001, 4'd0, 2'd0, "R9");
      cyc(1'b1, 3'd3, 32'h0000_0001, 4'd0, 2'd0, "R9");
      for (int k = 0; k < 3; k++) rd(3'd3, "R9");

      // R10: fatal alert latches and ignores zero writes
      cyc(1'b1, 3'd3, 32'h0000_0002, 4'd0, 2'd0, "R10");
      rd(3'd3, "R10");
      cyc(1'b1, 3'd3, 32'h0000_0000, 4'd0, 2'd0, "R10");
      for (int k = 0; k < 4; k++) rd(3'd3, "R10");

      // R11: unused addresses read zero and ignore writes
      for (int a = 4; a < 8; a++) begin
         cyc(1'b1, AW'(a), 32'hFFFF_FFFF, 4'd0, 2'd0, "R11");
         rd(AW'(a), "R11");
      end
      for (int a = 0; a < 4; a++) rd(AW'(a), "R11");

      // R1: reset again clears everything including the fatal latch
      cyc(1'b0, 3'd3, '0, 4'd0, 2'd0, "R1");
      rst_n = 1'b0;
      for (int a = 0; a < 4; a++) rd(AW'(a), "R1");

      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule